// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block turns single host requests into a sequence of commands for a single-data-rate SDRAM. After a start pulse it checks the requested burst length and CAS latency and writes them into the memory's mode register once. From then on it serves one request at a time. For each request it opens the row in the target bank and waits the activate-to-column delay. It then issues the read or write command with the column address. For a write it drives the burst onto the data bus. For a read it captures the returned beats at the programmed latency. Finally it closes the bank with a precharge.

The host sees a valid/ready handshake. `req_ready_o` stays low while the controller is unconfigured and while a request is in progress, including the precharge recovery time. Read beats come back on a separate valid/data/last stream. Burst length and CAS latency are runtime settings. The read capture window, the write drive window and the moment of the precharge all follow the programmed values, not fixed counts.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: A start pulse sampled at a clock edge with a legal setting makes the next cycle a LOAD MODE command (CS_n,RAS_n,CAS_n,WE_n = 0000, bank 0). Its address is {cas latency in bits 6:4, 0 in bit 3 for sequential bursts, burst code in bits 2:0 with 1→0, 2→1, 4→2, 8→3}, with all other bits 0. `init_done_o` is high from that cycle on.
- R2: A start pulse with burst length outside {1,2,4,8} or CAS latency outside {2,3} issues no command, sets `cfg_err_o` in the next cycle and leaves `init_done_o` low.
- R3: `req_ready_o` is low until configuration succeeds. A start pulse after a successful configuration is ignored: no further LOAD MODE, and no change to `init_done_o` or `cfg_err_o`.
- R4: A request accepted at an edge (valid and ready high) puts ACTIVE (0011) on the bus in the next cycle, carrying the request's bank on `ba_o` and its row on `addr_o`.
- R5: READ (0101) or WRITE (0100) appears exactly T_RCD cycles after ACTIVE, on the same bank. The column sits in the low address bits and address bit 10 is low.
- R6: For a read with latency CL and burst length BL, the value on `dq_i` in cycle CL+k after READ (k = 0..BL-1) is returned on `rd_data_o` with `rd_valid_o` one cycle later. `rd_last_o` marks the final beat, and `rd_valid_o` is low at all other times.
- R7: For a write, `dq_oe_o` is high for exactly BL cycles starting in the WRITE cycle. In the k-th of those cycles `dq_o` carries `req_wdata_i[k*DQ_W +: DQ_W]`.
- R8: PRECHARGE (0010, address bit 10 low, same bank) follows a write in the cycle after the last driven beat. It follows a read CL+BL cycles after READ.
- R9: ACTIVE comes no earlier than T_RP cycles after PRECHARGE. A request already waiting is accepted so that its ACTIVE lands exactly T_RP cycles after the PRECHARGE.
- R10: The first ACTIVE comes no earlier than T_MRD cycles after LOAD MODE, and exactly T_MRD cycles after it when a request is already waiting.
- R11: Reset leaves the bus at NOP (0111) with `dq_oe_o`, `rd_valid_o`, `req_ready_o`, `init_done_o` and `cfg_err_o` low. Every cycle not named above is a NOP, and `dqm_o` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that requests mode programming |
| cfg_bl_i | input | 4 | Burst length value (1, 2, 4 or 8) |
| cfg_cl_i | input | 2 | CAS latency value (2 or 3) |
| init_done_o | output | 1 | Mode register has been written |
| cfg_err_o | output | 1 | Last start carried an illegal setting |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BA_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Burst start column |
| req_wdata_i | input | 8*DQ_W | Write beats, beat k in bits k*DQ_W and up |
| rd_valid_o | output | 1 | Read beat valid |
| rd_data_o | output | DQ_W | Read beat data |
| rd_last_o | output | 1 | Final beat of the read burst |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row, column or mode word |
| dqm_o | output | DQ_W/8 | Byte masks, held low |
| dq_o | output | DQ_W | Write data to the memory |
| dq_oe_o | output | 1 | Output enable for dq_o |
| dq_i | input | DQ_W | Read data from the memory |

## Verification
A wrong wait counter shows up at the command pins: a READ, WRITE or ACTIVE lands on the wrong cycle. It is visible in the very cycle the command appears, before any data moves. A latched latency or burst length that is off shows up as read beats taken from the wrong bus cycle, or as a burst that is too long or too short. The late PRECHARGE and a missing or misplaced `rd_last_o` make this visible within one burst. A sequencer stuck in the wrong state shows up as `req_ready_o` staying low, or rising before the recovery time has passed. The next ACTIVE then moves off its exact expected cycle.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
  localparam int unsigned MAX_BL = 8;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_UNCFG,
    ST_WAIT,
    ST_ACT,
    ST_RD,
    ST_WR
  } seq_state_e;
endpackage

// File: rtl/sdram_mode_cfg.sv
module sdram_mode_cfg #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [3:0]        bl_i,
  input  logic [1:0]        cl_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] mode_o
);
  logic [2:0] bl_code;

  always_comb begin
    unique case (bl_i)
      4'd2:    bl_code = 3'd1;
      4'd4:    bl_code = 3'd2;
      4'd8:    bl_code = 3'd3;
      default: bl_code = 3'd0;
    endcase
  end

  assign valid_o = ($countones(bl_i) == 1) && (cl_i >= 2'd2);

  always_comb begin
    mode_o      = '0;
    mode_o[2:0] = bl_code;
    mode_o[3]   = 1'b0;  // sequential
    mode_o[6:4] = {1'b0, cl_i};
  end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int unsigned DQ_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      cl_i,
  input  logic [3:0]      bl_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic            valid_o,
  output logic [DQ_W-1:0] data_o,
  output logic            last_o,
  output logic            done_o
);
  logic       busy_q;
  logic [1:0] dly_q;
  logic [3:0] left_q;
  logic       win;

  assign win    = busy_q && (dly_q == 2'd0);
  assign done_o = win && (left_q == 4'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      dly_q   <= 2'd0;
      left_q  <= 4'd0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= win;
      last_o  <= done_o;
      if (win) data_o <= dq_i;
      if (start_i) begin
        busy_q <= 1'b1;
        dly_q  <= cl_i;  // counts the command cycle itself
        left_q <= bl_i;
      end else if (busy_q) begin
        if (dly_q != 2'd0) begin
          dly_q <= dly_q - 2'd1;
        end else begin
          left_q <= left_q - 4'd1;
          if (left_q == 4'd1) busy_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_wr_drive.sv
module sdram_wr_drive #(
  parameter int unsigned DQ_W   = 16,
  parameter int unsigned MAX_BL = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [3:0]             bl_i,
  input  logic [MAX_BL*DQ_W-1:0] burst_i,
  output logic [DQ_W-1:0]        dq_o,
  output logic                   oe_o,
  output logic                   last_o
);
  localparam int unsigned IDX_W = $clog2(MAX_BL);

  logic [IDX_W-1:0] idx_q;
  logic [3:0]       left_q;

  assign last_o = oe_o && (left_q == 4'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o   <= '0;
      oe_o   <= 1'b0;
      idx_q  <= '0;
      left_q <= 4'd0;
    end else if (start_i) begin
      dq_o   <= burst_i[DQ_W-1:0];
      oe_o   <= 1'b1;
      idx_q  <= IDX_W'(1);
      left_q <= bl_i - 4'd1;
    end else if (oe_o) begin
      if (left_q == 4'd0) begin
        oe_o <= 1'b0;
        dq_o <= '0;
      end else begin
        dq_o   <= burst_i[int'(idx_q)*DQ_W +: DQ_W];
        idx_q  <= idx_q + IDX_W'(1);
        left_q <= left_q - 4'd1;
      end
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int unsigned DQ_W   = 16,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_MRD  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [3:0]             cfg_bl_i,
  input  logic [1:0]             cfg_cl_i,
  output logic                   init_done_o,
  output logic                   cfg_err_o,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [BA_W-1:0]        req_bank_i,
  input  logic [ROW_W-1:0]       req_row_i,
  input  logic [COL_W-1:0]       req_col_i,
  input  logic [MAX_BL*DQ_W-1:0] req_wdata_i,
  output logic                   rd_valid_o,
  output logic [DQ_W-1:0]        rd_data_o,
  output logic                   rd_last_o,
  output logic                   cs_n_o,
  output logic                   ras_n_o,
  output logic                   cas_n_o,
  output logic                   we_n_o,
  output logic [BA_W-1:0]        ba_o,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [DQ_W/8-1:0]      dqm_o,
  output logic [DQ_W-1:0]        dq_o,
  output logic                   dq_oe_o,
  input  logic [DQ_W-1:0]        dq_i
);
  localparam int unsigned T_A   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int unsigned T_MAX = (T_A > T_MRD) ? T_A : T_MRD;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);
  localparam int unsigned BUR_W = MAX_BL * DQ_W;

  seq_state_e        state_q;
  sdram_cmd_e        cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BA_W-1:0]   bank_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [BUR_W-1:0]  wdata_q;
  logic [3:0]        bl_q;
  logic [1:0]        cl_q;

  logic              cfg_ok;
  logic [ADDR_W-1:0] mode_word;
  logic              col_go, rd_go, wr_go, rd_done, wr_last;

  sdram_mode_cfg #(.ADDR_W(ADDR_W)) u_mode (
    .bl_i    (cfg_bl_i),
    .cl_i    (cfg_cl_i),
    .valid_o (cfg_ok),
    .mode_o  (mode_word)
  );

  assign req_ready_o = (state_q == ST_WAIT) && (cnt_q == '0);
  assign col_go      = (state_q == ST_ACT) && (cnt_q == '0);
  assign rd_go       = col_go && !wr_q;
  assign wr_go       = col_go && wr_q;

  sdram_rd_capture #(.DQ_W(DQ_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rd_go),
    .cl_i    (cl_q),
    .bl_i    (bl_q),
    .dq_i    (dq_i),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o),
    .last_o  (rd_last_o),
    .done_o  (rd_done)
  );

  sdram_wr_drive #(.DQ_W(DQ_W), .MAX_BL(MAX_BL)) u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_go),
    .bl_i    (bl_q),
    .burst_i (wdata_q),
    .dq_o    (dq_o),
    .oe_o    (dq_oe_o),
    .last_o  (wr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_UNCFG;
      cmd_q       <= CMD_NOP;
      cnt_q       <= '0;
      ba_o        <= '0;
      addr_o      <= '0;
      bank_q      <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      bl_q        <= 4'd1;
      cl_q        <= 2'd2;
      init_done_o <= 1'b0;
      cfg_err_o   <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      unique case (state_q)
        ST_UNCFG: if (start_i) begin
          if (cfg_ok) begin
            cmd_q       <= CMD_LMR;
            ba_o        <= '0;
            addr_o      <= mode_word;
            bl_q        <= cfg_bl_i;
            cl_q        <= cfg_cl_i;
            init_done_o <= 1'b1;
            cfg_err_o   <= 1'b0;
            cnt_q       <= CNT_W'(T_MRD - 1);
            state_q     <= ST_WAIT;
          end else begin
            cfg_err_o <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (req_valid_i) begin
            cmd_q   <= CMD_ACT;
            ba_o    <= req_bank_i;
            addr_o  <= ADDR_W'(req_row_i);
            bank_q  <= req_bank_i;
            col_q   <= req_col_i;
            wr_q    <= req_write_i;
            wdata_q <= req_wdata_i;
            cnt_q   <= CNT_W'(T_RCD - 1);
            state_q <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            cmd_q   <= wr_q ? CMD_WR : CMD_RD;
            ba_o    <= bank_q;
            addr_o  <= ADDR_W'(col_q);  // bit 10 low: no auto precharge
            state_q <= wr_q ? ST_WR : ST_RD;
          end
        end
        ST_RD, ST_WR: begin
          if ((state_q == ST_RD) ? rd_done : wr_last) begin
            cmd_q   <= CMD_PRE;
            ba_o    <= bank_q;
            addr_o  <= '0;  // bit 10 low: this bank only
            cnt_q   <= CNT_W'(T_RP - 1);
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_UNCFG;
      endcase
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign dqm_o = '0;
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk #(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_MRD  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              dq_oe_o,
  input logic              req_ready_o,
  input logic              init_done_o,
  input logic              cfg_err_o
);
  logic [3:0]      cmd;
  logic [15:0]     since_act, since_pre, since_lmr;
  logic            seen_act, seen_pre, loaded;
  logic [BA_W-1:0] act_ba;
  logic            is_col;

  assign cmd    = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_col = (cmd == 4'b0101) || (cmd == 4'b0100);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '0;
      since_pre <= '0;
      since_lmr <= '0;
      seen_act  <= 1'b0;
      seen_pre  <= 1'b0;
      loaded    <= 1'b0;
      act_ba    <= '0;
    end else begin
      since_act <= (cmd == 4'b0011) ? 16'd1 : (since_act == 16'hffff ? since_act : since_act + 16'd1);
      since_pre <= (cmd == 4'b0010) ? 16'd1 : (since_pre == 16'hffff ? since_pre : since_pre + 16'd1);
      since_lmr <= (cmd == 4'b0000) ? 16'd1 : (since_lmr == 16'hffff ? since_lmr : since_lmr + 16'd1);
      if (cmd == 4'b0011) begin
        seen_act <= 1'b1;
        act_ba   <= ba_o;
      end
      if (cmd == 4'b0010) seen_pre <= 1'b1;
      if (cmd == 4'b0000) loaded <= 1'b1;
    end
  end

  assert_mode_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000) |-> !loaded);
  assert_ready_cfg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> !req_ready_o);
  assert_err_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !init_done_o);
  assert_col_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (seen_act && since_act >= 16'(T_RCD) && ba_o == act_ba && !addr_o[10]));
  assert_pre_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0011 && seen_pre) |-> since_pre >= 16'(T_RP));
  assert_mrd_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0011) |-> (loaded && since_lmr >= 16'(T_MRD)));
  assert_oe_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (cmd == 4'b0100));
  assert_legal_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd inside {4'b0111, 4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0000});
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(
  .BA_W(BA_W), .ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_MRD(T_MRD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .dq_oe_o     (dq_oe_o),
  .req_ready_o (req_ready_o),
  .init_done_o (init_done_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/sdram_seq_ctrl_bench.sv
module sdram_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DQ_W = 16, BA_W = 2, ROW_W = 12, COL_W = 8, ADDR_W = 12;
  localparam int T_RCD = 3, T_RP = 3, T_MRD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cfg_bl = 4'd1;
  logic [1:0] cfg_cl = 2'd2;
  logic init_done, cfg_err;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [BA_W-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [8*DQ_W-1:0] req_wdata = '0;
  logic rd_valid, rd_last;
  logic [DQ_W-1:0] rd_data, dq_o, dq_in = '0;
  logic cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W/8-1:0] dqm;

  sdram_seq_ctrl #(
    .DQ_W(DQ_W), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_MRD(T_MRD)
  ) u_sdram_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_bl_i(cfg_bl), .cfg_cl_i(cfg_cl),
    .init_done_o(init_done), .cfg_err_o(cfg_err), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_write_i(req_write), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .dqm_o(dqm), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed { logic [31:0] cyc; logic [3:0] cmd; logic [BA_W-1:0] ba; logic [ADDR_W-1:0] addr; } cmd_exp_t;
  typedef struct packed { logic [31:0] cyc; logic [DQ_W-1:0] data; logic last; } dat_exp_t;

  cmd_exp_t cmd_q[$];
  dat_exp_t rd_q[$];
  dat_exp_t wr_q[$];

  int cyc = 0;
  int n_checks = 0, n_fail = 0;
  int last_pre = 0, load_cyc = 0;
  int cur_bl = 1, cur_cl = 2;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DQ_W-1:0] pat(int c);
    return DQ_W'(c * 313) ^ 16'h5a3c;
  endfunction

  function automatic logic [8*DQ_W-1:0] mk_burst(int seed);
    logic [8*DQ_W-1:0] r;
    for (int k = 0; k < 8; k++) r[k*DQ_W +: DQ_W] = DQ_W'(seed * 4099 + k * 257 + 16'h1000);
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0011: return "R4";
      4'b0101, 4'b0100: return "R5";
      4'b0010: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  // Monitor: compares bus activity against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      chk(dqm == '0, "R11", "dqm", 32'(dqm), 0);
      if (c != 4'b0111) begin
        if (cmd_q.size() == 0) chk(0, "R11", "unexpected command", 32'(c), 32'h7);
        else begin
          cmd_exp_t e;
          e = cmd_q.pop_front();
          chk(cyc == e.cyc, tag_of(e.cmd), "command cycle", cyc, e.cyc);
          chk(c == e.cmd, tag_of(e.cmd), "command code", 32'(c), 32'(e.cmd));
          chk({ba, addr} == {e.ba, e.addr}, tag_of(e.cmd), "bank/address",
              32'({ba, addr}), 32'({e.ba, e.addr}));
        end
      end
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(0, "R6", "unexpected rd_valid", 1, 0);
        else begin
          dat_exp_t e;
          e = rd_q.pop_front();
          chk(cyc == e.cyc, "R6", "read beat cycle", cyc, e.cyc);
          chk(rd_data == e.data, "R6", "read data", 32'(rd_data), 32'(e.data));
          chk(rd_last == e.last, "R6", "read last", 32'(rd_last), 32'(e.last));
        end
      end
      if (dq_oe) begin
        if (wr_q.size() == 0) chk(0, "R7", "unexpected dq_oe", 1, 0);
        else begin
          dat_exp_t e;
          e = wr_q.pop_front();
          chk(cyc == e.cyc, "R7", "write beat cycle", cyc, e.cyc);
          chk(dq_o == e.data, "R7", "write data", 32'(dq_o), 32'(e.data));
        end
      end
    end
  end

  always @(negedge clk) dq_in <= pat(cyc);

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_q.delete(); rd_q.delete(); wr_q.delete();
    idle(2);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R11", "reset command", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
    chk({dq_oe, rd_valid, req_ready, init_done, cfg_err} == 5'b0, "R11", "reset flags",
        32'({dq_oe, rd_valid, req_ready, init_done, cfg_err}), 0);
    rst_n = 1'b1;
  endtask

  task automatic configure(input int bl, input int cl, input bit ok);
    int s;
    @(negedge clk);
    cfg_bl = 4'(bl); cfg_cl = 2'(cl); start = 1'b1;
    s = cyc + 1;
    if (ok) begin
      cmd_q.push_back({32'(s), 4'b0000, BA_W'(0), ADDR_W'((cl << 4) | $clog2(bl))});
      load_cyc = s; cur_bl = bl; cur_cl = cl;
    end
    @(negedge clk);
    start = 1'b0;
    chk(init_done == ok, ok ? "R1" : "R2", "init_done after start", 32'(init_done), 32'(ok));
    chk(cfg_err == !ok, "R2", "cfg_err after start", 32'(cfg_err), 32'(!ok));
    if (!ok) begin
      idle(4);
      chk(req_ready == 1'b0, "R3", "ready while unconfigured", 32'(req_ready), 0);
      chk(init_done == 1'b0, "R2", "init_done stays low", 32'(init_done), 0);
    end
  endtask

  // Driver: issues one request and pushes every expected bus event
  task automatic do_req(input bit wr, input int bank, input int row, input int col,
                        input int seed, input bit pinned, input int earliest, input string rq);
    int n, c, pre;
    logic [8*DQ_W-1:0] b;
    b = mk_burst(seed);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_bank = BA_W'(bank); req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = b;
    n = cyc + 1;
    if (pinned) chk(n == earliest, rq, "ACTIVE cycle after wait", n, earliest);
    c = n + T_RCD;
    cmd_q.push_back({32'(n), 4'b0011, BA_W'(bank), ADDR_W'(row)});
    cmd_q.push_back({32'(c), wr ? 4'b0100 : 4'b0101, BA_W'(bank), ADDR_W'(col)});
    if (wr) begin
      for (int k = 0; k < cur_bl; k++) wr_q.push_back({32'(c + k), b[k*DQ_W +: DQ_W], 1'b0});
      pre = c + cur_bl;
    end else begin
      for (int k = 0; k < cur_bl; k++)
        rd_q.push_back({32'(c + cur_cl + k + 1), pat(c + cur_cl + k), k == cur_bl - 1});
      pre = c + cur_cl + cur_bl;
    end
    cmd_q.push_back({32'(pre), 4'b0010, BA_W'(bank), ADDR_W'(0)});
    last_pre = pre;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    idle(30);
    chk(cmd_q.size() == 0, "R8", "pending commands", cmd_q.size(), 0);
    chk(rd_q.size() == 0, "R6", "pending read beats", rd_q.size(), 0);
    chk(wr_q.size() == 0, "R7", "pending write beats", wr_q.size(), 0);
  endtask

  task automatic run_pair(input int bl, input int cl, input int seed);
    do_reset();
    configure(bl, cl, 1'b1);
    do_req(1'b1, seed % 4, 100 + seed, 10 + seed, seed, 1'b1, load_cyc + T_MRD, "R10");
    do_req(1'b0, (seed + 1) % 4, 200 + seed, 20 + seed, 0, 1'b1, last_pre + T_RP, "R9");
    do_req(1'b0, (seed + 2) % 4, 300 + seed, 30, 0, 1'b1, last_pre + T_RP, "R9");
    drain();
  endtask

  initial begin
    do_reset();
    configure(3, 2, 1'b0);   // illegal burst length
    configure(4, 1, 1'b0);   // illegal latency
    configure(0, 3, 1'b0);
    configure(4, 2, 1'b1);
    do_req(1'b0, 1, 12'h5a5, 8'h20, 0, 1'b1, load_cyc + T_MRD, "R10");
    do_req(1'b1, 2, 12'h0f3, 8'h44, 3, 1'b1, last_pre + T_RP, "R9");
    do_req(1'b0, 3, 12'hfff, 8'hff, 0, 1'b1, last_pre + T_RP, "R9");
    drain();
    // start after configuration must be ignored
    @(negedge clk);
    cfg_bl = 4'd8; cfg_cl = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle(4);
    chk(init_done == 1'b1, "R3", "init_done after ignored start", 32'(init_done), 1);
    chk(cfg_err == 1'b0, "R3", "cfg_err after ignored start", 32'(cfg_err), 0);
    do_req(1'b0, 0, 12'h123, 8'h01, 0, 1'b0, 0, "R3");  // still BL4/CL2
    drain();
    run_pair(1, 3, 5);
    run_pair(8, 3, 7);
    run_pair(2, 2, 9);
    run_pair(8, 2, 11);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule